// File: doc/BRIEF.md
# Serial Clock Freeze Controller

This block receives a short serial command that says which of a set of distributed clocks may run, and applies that command to each clock without ever cutting a high phase short. A command frame opens with a low start bit and carries one enable bit per controllable clock. Data is sampled on the rising edge of the serial clock. The finished word becomes active only once its last bit has arrived.

Each clock output has its own gate. The gate retimes its enable into the clock's own domain and changes state only on that clock's falling edge. An output therefore starts or stops on a whole high phase. A frozen output sits at logic 0. One output of bank C and the feedback clock have no gate and always run, so a bad command can never stop the loop that generates the clocks.

Top module: `frz_ctrl_top`

## Requirements
- R1: A frame is a serial data value of 0 sampled on a rising serial-clock edge while idle (the start bit), followed by 12 data bits sampled on the next 12 rising edges.
- R2: The first data bit after the start bit is word bit 0. Bits 0-3 enable bank A outputs 0-3. Bits 4-7 enable bank B outputs 0-3. Bits 8-10 enable bank C outputs 1-3. Bit 11 enables the sync output. `en_word_o` shows the active word with the same bit positions.
- R3: When an output's word bit is 1, that output equals its source clock. When the bit is 0, the output is held at logic 0.
- R4: Bank C output 0 and the feedback output always equal their source clocks, whatever the word holds.
- R5: `en_word_o` changes on the rising serial-clock edge that samples the 12th data bit. An unfinished frame leaves it unchanged.
- R6: While idle, a serial data value of 1 is ignored. The receiver stays idle and the word is unchanged.
- R7: A gate changes state only while its own clock is low. Every output high pulse starts and ends together with a source-clock high pulse, so no shortened pulse can appear.
- R8: A synchronous active-high reset sets every word bit to 1, returns the receiver to idle, and leaves every output running. This includes a reset that arrives in the middle of a frame.
- R9: A new start bit may be sampled on the rising edge right after the last data bit of the previous frame. Both words are then applied in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial command clock |
| sdata_i | input | 1 | Serial command data, sampled on rising sclk_i |
| clk_a_i | input | 4 | Bank A source clocks |
| clk_b_i | input | 4 | Bank B source clocks |
| clk_c_i | input | 4 | Bank C source clocks |
| clk_sync_i | input | 1 | Sync source clock |
| clk_fb_i | input | 1 | Feedback source clock |
| clk_a_o | output | 4 | Gated bank A clocks |
| clk_b_o | output | 4 | Gated bank B clocks; |
| clk_c_o | output | 4 | Bank C clocks; bit 0 is never gated |
| clk_sync_o | output | 1 | Gated sync clock |
| clk_fb_o | output | 1 | Feedback clock, never gated |
| en_word_o | output | 12 | Active enable word |

## Verification
Two events can land on the same serial-clock edge: the transfer of a finished word and the sampling of the next frame's start bit. The bench provokes this by sending two frames back to back with no idle bit between them. It then judges that both words are applied in turn and that neither frame loses a bit. At each gate, an enable change can also arrive right at a falling edge of that gate's own clock. Clocks with periods of 4, 6 and 8 ns slide against the serial clock, so changes arrive at every phase. A monitor on every output checks that each output rising edge coincides with a source rising edge and that each output falling edge happens while the source is low.

// File: rtl/frz_pkg.sv
`timescale 1ns/100ps
package frz_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_SHIFT = 1'b1} rx_state_t;
endpackage

// File: rtl/frz_serial_rx.sv
`timescale 1ns/100ps
module frz_serial_rx
  import frz_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         sclk_i,
  input  logic         rst_i,
  input  logic         sdata_i,
  output logic [W-1:0] word_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  rx_state_t      state_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   shift_q;
  logic [W-1:0]   shift_nx;

  // LSB-first: the first data bit ends up in bit 0
  assign shift_nx = {sdata_i, shift_q[W-1:1]};

  always_ff @(posedge sclk_i) begin
    if (rst_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      word_o  <= '1;
    end else begin
      case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!sdata_i) state_q <= RX_SHIFT;
        end
        default: begin
          shift_q <= shift_nx;
          if (cnt_q == LAST) begin
            word_o  <= shift_nx;
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assert_cnt_range_R1: assert property (@(posedge sclk_i) disable iff (rst_i)
    cnt_q <= LAST);

  assert_frame_end_R5: assert property (@(posedge sclk_i) disable iff (rst_i)
    (state_q == RX_SHIFT && cnt_q == LAST) |=> state_q == RX_IDLE);

  assert_word_hold_R5: assert property (@(posedge sclk_i) disable iff (rst_i)
    (state_q == RX_SHIFT && cnt_q != LAST) |=> $stable(word_o));

  assert_idle_hold_R6: assert property (@(posedge sclk_i) disable iff (rst_i)
    (state_q == RX_IDLE && sdata_i) |=> (state_q == RX_IDLE && $stable(word_o)));

  assert_reset_ones_R8: assert property (@(posedge sclk_i)
    rst_i |=> (word_o == '1 && state_q == RX_IDLE));
endmodule

// File: rtl/frz_clk_gate.sv
`timescale 1ns/100ps
module frz_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   gate_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= '1;
    else       sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
  end

  // gate moves only at the falling edge, i.e. while the clock is low
  always_ff @(negedge clk_i) begin
    if (rst_i) gate_q <= 1'b1;
    else       gate_q <= sync_q[SYNC_STAGES-1];
  end

  assign clk_o = clk_i & gate_q;

  always @(gate_q) begin
    if (!rst_i) begin
      assert_gate_low_R7: assert (clk_i == 1'b0);
    end
  end
endmodule

// File: rtl/frz_ctrl_top.sv
`timescale 1ns/100ps
module frz_ctrl_top #(
  parameter int BANK_W = 4,
  parameter int WORD_W = 3 * BANK_W
) (
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [BANK_W-1:0] clk_a_i,
  input  logic [BANK_W-1:0] clk_b_i,
  input  logic [BANK_W-1:0] clk_c_i,
  input  logic              clk_sync_i,
  input  logic              clk_fb_i,
  output logic [BANK_W-1:0] clk_a_o,
  output logic [BANK_W-1:0] clk_b_o,
  output logic [BANK_W-1:0] clk_c_o,
  output logic              clk_sync_o,
  output logic              clk_fb_o,
  output logic [WORD_W-1:0] en_word_o
);
  localparam int B_BASE = BANK_W;
  localparam int C_BASE = 2 * BANK_W;
  localparam int S_BIT  = WORD_W - 1;

  frz_serial_rx #(.W(WORD_W)) u_rx (
    .sclk_i (sclk_i),
    .rst_i  (rst_i),
    .sdata_i(sdata_i),
    .word_o (en_word_o)
  );

  for (genvar i = 0; i < BANK_W; i++) begin : g_bank
    frz_clk_gate u_gate_a (
      .clk_i(clk_a_i[i]), .rst_i(rst_i), .en_i(en_word_o[i]), .clk_o(clk_a_o[i])
    );
    frz_clk_gate u_gate_b (
      .clk_i(clk_b_i[i]), .rst_i(rst_i), .en_i(en_word_o[B_BASE+i]), .clk_o(clk_b_o[i])
    );
    if (i == 0) begin : g_c_free
      assign clk_c_o[i] = clk_c_i[i];
    end else begin : g_c_gated
      frz_clk_gate u_gate_c (
        .clk_i(clk_c_i[i]), .rst_i(rst_i), .en_i(en_word_o[C_BASE+i-1]), .clk_o(clk_c_o[i])
      );
    end
  end

  frz_clk_gate u_gate_sync (
    .clk_i(clk_sync_i), .rst_i(rst_i), .en_i(en_word_o[S_BIT]), .clk_o(clk_sync_o)
  );

  assign clk_fb_o = clk_fb_i;
endmodule

// File: tb/tb_frz_ctrl_top.sv
`timescale 1ns/100ps
module tb_frz_ctrl_top;
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{12'h000, 12'hFFF, 12'hA5A, 12'h801, 12'h3C7, 12'hFFE};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdata = 1'b1;
  logic [13:0] gin = '0;
  logic [13:0] gout;
  logic [11:0] en_word;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          armed = 1'b0;
  bit          done = 1'b0;
  int          runt_cnt [14];
  realtime     last_rise [14];

  always #2 clk = ~clk;

  // source clocks: half periods 2, 3 and 4 ns
  initial begin
    int t;
    t = 0;
    forever begin
      #1 t++;
      for (int g = 0; g < 14; g++) gin[g] = ((t / (2 + g % 3)) % 2) == 1;
    end
  end

  frz_ctrl_top dut (
    .rst_i(rst), .sclk_i(clk), .sdata_i(sdata),
    .clk_a_i(gin[3:0]), .clk_b_i(gin[7:4]), .clk_c_i(gin[11:8]),
    .clk_sync_i(gin[12]), .clk_fb_i(gin[13]),
    .clk_a_o(gout[3:0]), .clk_b_o(gout[7:4]), .clk_c_o(gout[11:8]),
    .clk_sync_o(gout[12]), .clk_fb_o(gout[13]),
    .en_word_o(en_word)
  );

  // R7 monitor: output edges must coincide with source edges
  for (genvar g = 0; g < 14; g++) begin : g_mon
    initial runt_cnt[g] = 0;
    always @(posedge gin[g]) last_rise[g] = $realtime;
    always @(posedge gout[g]) begin
      realtime rt;
      rt = $realtime;
      #0.1;
      if (armed && last_rise[g] != rt) runt_cnt[g]++;
    end
    always @(negedge gout[g]) begin
      #0.1;
      if (armed && gin[g] !== 1'b0) runt_cnt[g]++;
    end
  end

  function automatic logic [13:0] exp_en(input logic [11:0] w);
    return {1'b1, w[11], w[10:8], 1'b1, w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_outputs(input logic [11:0] w, input string req);
    logic [13:0] e;
    logic [13:0] bad;
    logic [13:0] a_seen;
    logic [13:0] e_seen;
    e = exp_en(w);
    bad = '0; a_seen = '0; e_seen = '0;
    #60.5;
    for (int s = 0; s < 100; s++) begin
      for (int g = 0; g < 14; g++) begin
        logic ev;
        ev = e[g] ? gin[g] : 1'b0;
        if (gout[g] !== ev && !bad[g]) begin
          bad[g] = 1'b1; a_seen[g] = gout[g]; e_seen[g] = ev;
        end
      end
      #1;
    end
    for (int g = 0; g < 14; g++)
      chk(!bad[g], (g == 8 || g == 13) ? "R4" : req, {31'd0, a_seen[g]}, {31'd0, e_seen[g]});
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [11:0] w, input int first, input int last);
    for (int b = first; b <= last; b++) begin
      sdata = w[b];
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [11:0] w);
    sdata = 1'b0;
    @(negedge clk);
    send_bits(w, 0, 11);
  endtask

  initial begin
    repeat (12) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    armed = 1'b1;
    chk(en_word == 12'hFFF, "R8", {20'd0, en_word}, 32'hFFF);
    check_outputs(12'hFFF, "R8");

    repeat (20) @(negedge clk);
    chk(en_word == 12'hFFF, "R6", {20'd0, en_word}, 32'hFFF);

    for (int k = 0; k < NV; k++) begin
      send_frame(VEC[k]);
      sdata = 1'b1;
      chk(en_word == VEC[k], "R1", {20'd0, en_word}, {20'd0, VEC[k]});
      check_outputs(VEC[k], "R3");
    end

    // R5: partial frame leaves the word, last bit transfers it
    sdata = 1'b0;
    @(negedge clk);
    send_bits(12'h5A3, 0, 10);
    chk(en_word == 12'hFFE, "R5", {20'd0, en_word}, 32'hFFE);
    send_bits(12'h5A3, 11, 11);
    sdata = 1'b1;
    chk(en_word == 12'h5A3, "R5", {20'd0, en_word}, 32'h5A3);

    // R6: long idle high with a non-default word
    repeat (30) @(negedge clk);
    chk(en_word == 12'h5A3, "R6", {20'd0, en_word}, 32'h5A3);
    check_outputs(12'h5A3, "R6");

    // R9: back-to-back frames
    send_frame(12'h0F0);
    chk(en_word == 12'h0F0, "R9", {20'd0, en_word}, 32'h0F0);
    send_frame(12'h333);
    sdata = 1'b1;
    chk(en_word == 12'h333, "R9", {20'd0, en_word}, 32'h333);
    check_outputs(12'h333, "R9");

    // R2: a single set bit lands on word bit 0 only
    send_frame(12'h001);
    sdata = 1'b1;
    chk(en_word == 12'h001, "R2", {20'd0, en_word}, 32'h001);
    check_outputs(12'h001, "R2");

    // R8: reset in the middle of a frame
    sdata = 1'b0;
    @(negedge clk);
    send_bits(12'h000, 0, 4);
    sdata = 1'b1;
    rst = 1'b1;
    repeat (12) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(en_word == 12'hFFF, "R8", {20'd0, en_word}, 32'hFFF);
    repeat (15) @(negedge clk);
    chk(en_word == 12'hFFF, "R8", {20'd0, en_word}, 32'hFFF);
    check_outputs(12'hFFF, "R8");

    for (int g = 0; g < 14; g++)
      chk(runt_cnt[g] == 0, "R7", runt_cnt[g], 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule